// File: doc/BRIEF.md
# Serial Display Data Receiver

This block is the serial input port of a segment LCD driver with 32 segment lines and 3 common lines, 96 cells in all. A host drives a chip-select, a serial clock and a data line. While chip-select is high, each rising serial-clock edge shifts one data bit in. A complete transfer carries 96 display bits followed by an 8-bit control code. The display bits and the control flags are committed to the outputs only when chip-select falls, so the panel never shows a half-loaded frame.

All three host lines are asynchronous to the block. Each passes through a synchroniser into the system clock domain, and edges are detected there. This requires a system clock at least four times faster than the serial clock. The serial clock may rest either high or low between transfers. A transfer that ends with any bit count other than 104 is rejected. In that case the outputs keep their previous contents and a one-cycle error pulse is raised.

Top module: `segdisp_rx`

## Requirements
- R1: While `cs_in` is low, activity on `ck_in` and `di_in` changes neither the display outputs, the flag outputs nor `frame_err_o`.
- R2: While `cs_in` is high, `di_in` is captured on each rising edge of `ck_in`. The first bit captured in a transfer is display bit D1 and the 96th is D96.
- R3: A valid transfer has exactly 104 bits. Bits 97 to 101 are fillers whose values are not used. Bit 102 sets `half_bias_o`, bit 103 sets `low_power_o` and bit 104 sets `blank_o`, each active when 1.
- R4: Outputs do not change while a transfer is in progress, including after its last bit. They take the new values only after `cs_in` falls, within 3 system clock cycles of the fall reaching the input.
- R5: Segment k (1..32) on common c (1..3) is driven by `seg_data_o[3*(k-1)+(c-1)]`, which holds display bit D(3k+1-c). D1 therefore appears at index 2 and D96 at index 93.
- R6: While `rst_n` is low, all display bits, all three flags and the bit counter are cleared. A transfer interrupted by reset commits nothing.
- R7: Transfers work the same whether `ck_in` rests low or high while chip-select is low.
- R8: When `cs_in` falls after a count other than 104 (zero bits, too few, or too many), the display and flag outputs keep their values and `frame_err_o` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_in | input | 1 | Chip select from host, transfer window while high |
| ck_in | input | 1 | Serial clock from host |
| di_in | input | 1 | Serial data from host |
| seg_data_o | output | 96 | Committed display cells, three per segment |
| half_bias_o | output | 1 | Committed half-bias mode flag |
| low_power_o | output | 1 | Committed low-power flag |
| blank_o | output | 1 | Committed output-blank flag |
| frame_err_o | output | 1 | One-cycle pulse for a rejected transfer |

## Verification
On every cycle, the assertions check four things. The bit counter and shift register stay frozen while the synchronised chip-select is low. Each accepted clock edge advances the count by one and brings in the current data bit. The committed display and flags move only in the cycle after a detected chip-select fall. An error pulse lasts one cycle and leaves the committed state untouched. Other behaviours can only be shown by the bench's scenarios, which compare outputs with a scoreboard model. These are the bit-to-segment mapping, the control bit positions, operation with either resting clock level, rejection of short, long and empty transfers, and recovery from a reset in mid-transfer.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;

    // lane positions inside the synchroniser vector
    localparam int LANE_CS = 0;
    localparam int LANE_CK = 1;
    localparam int LANE_DI = 2;
    localparam int LANES   = 3;

    // positions of the mode flags within the trailing control field
    localparam int FLAG_BLANK = 0;
    localparam int FLAG_LOWPW = 1;
    localparam int FLAG_HBIAS = 2;

    typedef struct packed {
        logic half_bias;
        logic low_power;
        logic blank;
    } mode_flags_t;

endpackage

// File: rtl/segdisp_sync.sv
module segdisp_sync
    import segdisp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_in,
    input  logic ck_in,
    input  logic di_in,
    output logic cs_lvl,
    output logic di_lvl,
    output logic ck_rise,
    output logic cs_rise,
    output logic cs_fall
);

    typedef struct packed {
        logic [STAGES-1:0][LANES-1:0] pipe;
        logic [LANES-1:0]             last;
    } sync_t;

    sync_t s_d, s_q;
    logic [LANES-1:0] now_v;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0][LANE_CS] = cs_in;
        s_d.pipe[0][LANE_CK] = ck_in;
        s_d.pipe[0][LANE_DI] = di_in;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
        s_d.last = s_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign now_v   = s_q.pipe[STAGES-1];
    assign cs_lvl  = now_v[LANE_CS];
    assign di_lvl  = now_v[LANE_DI];
    assign ck_rise = now_v[LANE_CK] & ~s_q.last[LANE_CK];
    assign cs_rise = now_v[LANE_CS] & ~s_q.last[LANE_CS];
    assign cs_fall = ~now_v[LANE_CS] & s_q.last[LANE_CS];

endmodule

// File: rtl/segdisp_shift.sv
module segdisp_shift #(
    parameter int FRAME_BITS = 104,
    parameter int CNT_W      = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_lvl,
    input  logic                  cs_rise,
    input  logic                  ck_rise,
    input  logic                  di_lvl,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic [CNT_W-1:0]      count_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);

    typedef struct packed {
        logic [FRAME_BITS-1:0] sr;
        logic [CNT_W-1:0]      cnt;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (cs_rise) begin
            sh_d.cnt = '0;
        end else if (cs_lvl && ck_rise) begin
            sh_d.sr = {sh_q.sr[FRAME_BITS-2:0], di_lvl};
            if (sh_q.cnt != CNT_MAX) begin
                sh_d.cnt = sh_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign frame_o = sh_q.sr;
    assign count_o = sh_q.cnt;

    // R1: nothing moves while chip select is low
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_lvl |=> ($stable(sh_q.cnt) && $stable(sh_q.sr)));

    // R2: an accepted clock edge advances the count by one
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && ck_rise && !cs_rise && sh_q.cnt < CNT_FULL)
            |=> sh_q.cnt == $past(sh_q.cnt) + CNT_W'(1));

    // R2: the newest bit is the data level seen at the accepted edge
    p_bit_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && ck_rise && !cs_rise) |=> sh_q.sr[0] == $past(di_lvl));

endmodule

// File: rtl/segdisp_commit.sv
module segdisp_commit
    import segdisp_pkg::*;
#(
    parameter int SEG_COUNT = 32,
    parameter int COM_COUNT = 3,
    parameter int CTRL_BITS = 8,
    parameter int CNT_W     = 7
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cs_fall,
    input  logic [SEG_COUNT*COM_COUNT+CTRL_BITS-1:0] frame_i,
    input  logic [CNT_W-1:0]                   count_i,
    output logic [SEG_COUNT*COM_COUNT-1:0]     disp_o,
    output mode_flags_t                        flags_o,
    output logic                               err_o
);

    localparam int DISP_BITS  = SEG_COUNT * COM_COUNT;
    localparam int FRAME_BITS = DISP_BITS + CTRL_BITS;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic [DISP_BITS-1:0] disp;
        mode_flags_t          flags;
        logic                 err;
    } commit_t;

    commit_t cm_d, cm_q;
    logic [DISP_BITS-1:0] disp_new;
    mode_flags_t          flags_new;

    // serial bit n (1-based) sits at frame position FRAME_BITS-n;
    // segment s, common c takes bit n = COM_COUNT*s + COM_COUNT - c
    for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
        for (genvar c = 0; c < COM_COUNT; c++) begin : g_com
            assign disp_new[s*COM_COUNT + c] =
                frame_i[FRAME_BITS - (s*COM_COUNT + COM_COUNT - c)];
        end
    end

    assign flags_new.half_bias = frame_i[FLAG_HBIAS];
    assign flags_new.low_power = frame_i[FLAG_LOWPW];
    assign flags_new.blank     = frame_i[FLAG_BLANK];

    always_comb begin
        cm_d     = cm_q;
        cm_d.err = 1'b0;
        if (cs_fall) begin
            if (count_i == CNT_FULL) begin
                cm_d.disp  = disp_new;
                cm_d.flags = flags_new;
            end else begin
                cm_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cm_q <= '0;
        else        cm_q <= cm_d;
    end

    assign disp_o  = cm_q.disp;
    assign flags_o = cm_q.flags;
    assign err_o   = cm_q.err;

    // R4: committed state changes only after a chip-select fall
    p_commit_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall |=> ($stable(cm_q.disp) && $stable(cm_q.flags)));

    // R8: a rejection pulse lasts a single cycle
    p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cm_q.err |=> !cm_q.err);

    // R8: a rejected transfer leaves the committed state as it was
    p_err_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cm_q.err |-> ($stable(cm_q.disp) && $stable(cm_q.flags)));

    // R8: a pulse is caused only by a fall with a wrong count
    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cm_q.err |-> ($past(cs_fall) && $past(count_i) != CNT_FULL));

endmodule

// File: rtl/segdisp_rx.sv
module segdisp_rx
    import segdisp_pkg::*;
#(
    parameter int SEG_COUNT   = 32,
    parameter int COM_COUNT   = 3,
    parameter int CTRL_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cs_in,
    input  logic                           ck_in,
    input  logic                           di_in,
    output logic [SEG_COUNT*COM_COUNT-1:0] seg_data_o,
    output logic                           half_bias_o,
    output logic                           low_power_o,
    output logic                           blank_o,
    output logic                           frame_err_o
);

    localparam int DISP_BITS  = SEG_COUNT * COM_COUNT;
    localparam int FRAME_BITS = DISP_BITS + CTRL_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    logic                  cs_lvl, di_lvl, ck_rise, cs_rise, cs_fall;
    logic [FRAME_BITS-1:0] frame;
    logic [CNT_W-1:0]      count;
    mode_flags_t           flags;

    segdisp_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_in   (cs_in),
        .ck_in   (ck_in),
        .di_in   (di_in),
        .cs_lvl  (cs_lvl),
        .di_lvl  (di_lvl),
        .ck_rise (ck_rise),
        .cs_rise (cs_rise),
        .cs_fall (cs_fall)
    );

    segdisp_shift #(
        .FRAME_BITS (FRAME_BITS),
        .CNT_W      (CNT_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_lvl  (cs_lvl),
        .cs_rise (cs_rise),
        .ck_rise (ck_rise),
        .di_lvl  (di_lvl),
        .frame_o (frame),
        .count_o (count)
    );

    segdisp_commit #(
        .SEG_COUNT (SEG_COUNT),
        .COM_COUNT (COM_COUNT),
        .CTRL_BITS (CTRL_BITS),
        .CNT_W     (CNT_W)
    ) u_commit (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_fall (cs_fall),
        .frame_i (frame),
        .count_i (count),
        .disp_o  (seg_data_o),
        .flags_o (flags),
        .err_o   (frame_err_o)
    );

    assign half_bias_o = flags.half_bias;
    assign low_power_o = flags.low_power;
    assign blank_o     = flags.blank;

endmodule

// File: tb/segdisp_rx_test.sv
module segdisp_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        cs_in = 1'b0;
    logic        ck_in = 1'b0;
    logic        di_in = 1'b0;
    logic [95:0] seg_data_o;
    logic        half_bias_o, low_power_o, blank_o, frame_err_o;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;

    typedef struct {
        logic [95:0] disp;
        logic [2:0]  flags;
        int          errs;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [95:0] m_disp = '0;
    logic [2:0]  m_flags = '0;
    int          m_errs = 0;

    always #10 clk = ~clk;

    segdisp_rx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_in       (cs_in),
        .ck_in       (ck_in),
        .di_in       (di_in),
        .seg_data_o  (seg_data_o),
        .half_bias_o (half_bias_o),
        .low_power_o (low_power_o),
        .blank_o     (blank_o),
        .frame_err_o (frame_err_o)
    );

    always @(negedge clk) if (frame_err_o) err_seen++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [95:0] map_disp(input logic [95:0] d);
        logic [95:0] e = '0;
        for (int n = 1; n <= 96; n++) begin
            int s = (n - 1) / 3;
            int c = 2 - ((n - 1) % 3);
            e[s*3 + c] = d[n-1];
        end
        return e;
    endfunction

    function automatic logic [2:0] cur_flags();
        return {half_bias_o, low_power_o, blank_o};
    endfunction

    task automatic check_state(input string tag, input logic [95:0] ed,
                               input logic [2:0] ef, input int ee);
        check(seg_data_o === ed, {tag, " display"}, seg_data_o, ed);
        check(cur_flags() === ef, {tag, " flags"}, 96'(cur_flags()), 96'(ef));
        check(err_seen == ee, {tag, " error pulses"}, 96'(err_seen), 96'(ee));
    endtask

    // driver: pushes the expected result once chip select has dropped
    task automatic send(input logic [95:0] d, input logic bm, input logic lc,
                        input logic oe, input int nbits, input bit idle_hi,
                        input string tag);
        exp_t item;
        tick(1);
        ck_in = idle_hi;
        cs_in = 1'b1;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            if (i < 96)       b = d[i];
            else if (i < 101) b = 1'b0;
            else if (i == 101) b = bm;
            else if (i == 102) b = lc;
            else if (i == 103) b = oe;
            else              b = 1'b1;
            if (idle_hi) begin
                ck_in = 1'b0; di_in = b; tick(4);
                ck_in = 1'b1; tick(4);
            end else begin
                di_in = b; tick(4);
                ck_in = 1'b1; tick(4);
                ck_in = 1'b0;
            end
        end
        tick(6);
        // R4: nothing committed while chip select is still high
        check_state({tag, " R4 before fall"}, m_disp, m_flags, m_errs);
        cs_in = 1'b0;
        if (nbits == 104) begin
            m_disp  = map_disp(d);
            m_flags = {bm, lc, oe};
        end else begin
            m_errs++;
        end
        item.disp = m_disp; item.flags = m_flags; item.errs = m_errs; item.tag = tag;
        sb_q.push_back(item);
        tick(14);
    endtask

    // monitor: pops each expected result and compares once it is due
    initial begin
        forever begin
            exp_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            repeat (6) @(negedge clk);
            check_state(it.tag, it.disp, it.flags, it.errs);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3 rst_n = 1'b0;
        tick(4);
        check_state("R6 reset state", '0, 3'b000, 0);
        rst_n = 1'b1;
        tick(4);

        send(96'h0123_4567_89AB_CDEF_FEDC_BA98, 1'b1, 1'b0, 1'b1, 104, 1'b0,
             "R2 R3 R5 idle-low frame");
        send(96'hDEAD_BEEF_0F0F_F0F0_1357_9BDF, 1'b0, 1'b1, 1'b0, 104, 1'b1,
             "R7 R3 idle-high frame");
        send(96'h1, 1'b0, 1'b0, 1'b0, 104, 1'b0, "R5 D1 alone");
        check(seg_data_o[2] === 1'b1 && $countones(seg_data_o) == 1,
              "R5 D1 at index 2", seg_data_o, 96'h4);
        send(96'h1 << 95, 1'b1, 1'b1, 1'b0, 104, 1'b1, "R5 D96 alone");
        check(seg_data_o[93] === 1'b1 && $countones(seg_data_o) == 1,
              "R5 D96 at index 93", seg_data_o, 96'h1 << 93);
        send(96'hFFFF_0000_FFFF_0000_FFFF_0000, 1'b0, 1'b0, 1'b1, 100, 1'b0,
             "R8 short transfer");
        send(96'h5555_5555_5555_5555_5555_5555, 1'b1, 1'b0, 1'b0, 105, 1'b1,
             "R8 long transfer");
        send('0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R8 empty transfer");

        // R1: toggle clock and data with chip select low
        for (int i = 0; i < 20; i++) begin
            di_in = i[0] ^ i[2];
            ck_in = ~ck_in;
            tick(4);
        end
        ck_in = 1'b0;
        tick(8);
        check_state("R1 ignored while deselected", m_disp, m_flags, m_errs);

        send({96{1'b1}}, 1'b1, 1'b1, 1'b1, 104, 1'b1, "R7 R3 all ones");

        // R6: reset during a transfer
        tick(1);
        cs_in = 1'b1;
        for (int i = 0; i < 50; i++) begin
            di_in = 1'b0; tick(4);
            ck_in = 1'b1; tick(4);
            ck_in = 1'b0;
        end
        rst_n = 1'b0;
        cs_in = 1'b0;
        m_disp = '0;
        m_flags = '0;
        tick(3);
        rst_n = 1'b1;
        tick(10);
        check_state("R6 reset mid transfer", '0, 3'b000, m_errs);

        send(96'hCAFE_F00D_8421_1248_ACE0_BD19, 1'b0, 1'b1, 1'b1, 104, 1'b0,
             "R6 R2 frame after reset");

        wait (sb_q.size() == 0);
        tick(10);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule